// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small programmable logic device: a configurable AND plane feeding a fixed OR plane. Fourteen dedicated inputs and eight feedback signals each produce a true and an inverted copy, which gives 44 array lines. Each product term is the AND of the lines whose connection bit is set. An unconnected term is constant true. A term tied to both copies of one signal is constant false.

There are 74 terms in all. Eight groups of eight terms form eight OR outputs. Eight more terms give per-output enables, and two terms give global preset and clear controls. All of these appear as combinational outputs. Output macrocells, pins and electrical timing lie outside this block.

The connection map lives in internal registers. It is loaded one bit per clock through a serial port and read back through a second serial port in the same order. A bulk erase opens every connection. A security command locks the map against both readback and reprogramming. Only a bulk erase removes the lock.

Top module: `sop_array`

## Requirements
- R1: Signal s (dedicated input i is s = i, feedback j is s = N_IN + j) drives array line 2s with its true value and line 2s+1 with its complement.
- R2: A product term is the AND of every line whose connection bit is 1. A term with no bit set is 1. A term whose bits select both lines of one signal is always 0.
- R3: Term numbering is fixed. Terms 0 to N_OUT*TPO-1 are sum terms, and `sum_out[k]` is the OR of terms k*TPO to k*TPO+TPO-1. The next N_OUT terms drive `oe_term[k]`. Then comes the preset term, then the clear term. All of these outputs are combinational.
- R4: Each clock with `cfg_load` high, `cmd_erase` low and the map unlocked writes `cfg_din` at the write pointer and advances the pointer. The bit order is term-major: term 0 line 0 first, bit index = term*LINES + line. The pointer wraps to 0 after the last bit and holds while `cfg_load` is low.
- R5: Each clock with `cfg_read` high and the map unlocked presents, on the next cycle, the bit at an independent read pointer on `cfg_dout`, in the same order as R4, and advances that pointer.
- R6: After reset every connection bit is 0, the map is unlocked, both pointers are 0 and `cfg_dout` is 0.
- R7: `cmd_erase` clears every connection bit, the lock, both pointers and `cfg_dout`. It takes priority over a load, read or secure in the same cycle.
- R8: `cmd_secure` sets the lock only when the write pointer is 0 and `cfg_load` is low. A lock request in the middle of a load is ignored.
- R9: While locked, loads change neither the map nor the write pointer, and reads return 0 on `cfg_dout`.
- R10: The lock is cleared only by `cmd_erase` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_ded | input | N_IN | Dedicated array inputs |
| in_fb | input | N_FB | Feedback array inputs |
| cfg_load | input | 1 | Serial load enable |
| cfg_din | input | 1 | Serial load data bit |
| cfg_read | input | 1 | Serial readback request |
| cfg_dout | output | 1 | Readback data, one cycle after request |
| cmd_erase | input | 1 | Bulk erase command |
| cmd_secure | input | 1 | Lock command |
| sum_out | output | N_OUT | OR of each group of sum terms |
| oe_term | output | N_OUT | Per-output enable terms |
| preset_term | output | 1 | Global preset term |
| clear_term | output | 1 | Global clear term |

## Verification
The checker relies on the command pins being sampled only at rising clock edges. It also assumes reset is applied before any command, so that lock and pointer state begin known. The bench changes commands and data only on falling edges and pulses each command for exactly one cycle. It sweeps the array inputs only while no load is in progress, so every combinational output it samples reflects a settled map. Each sweep covers all input combinations on a reduced configuration of three dedicated inputs, two feedbacks, two outputs and two terms per output.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef struct packed {
        logic load;
        logic din;
        logic read;
        logic erase;
        logic secure;
    } cfg_req_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_ERASE  = 2'd1,
        ACT_SECURE = 2'd2
    } ctl_act_e;

    function automatic int line_count(int n_in, int n_fb);
        return 2 * (n_in + n_fb);
    endfunction

    function automatic int term_count(int n_out, int tpo);
        return n_out * tpo + n_out + 2;
    endfunction

    // Erase outranks everything; a lock request needs an idle, unlocked store.
    function automatic ctl_act_e pick_action(logic erase, logic secure, logic locked,
                                             logic idle, logic load);
        if (erase)
            return ACT_ERASE;
        if (secure && !locked && idle && !load)
            return ACT_SECURE;
        return ACT_NONE;
    endfunction

endpackage

// File: rtl/sop_line_expand.sv
module sop_line_expand #(
    parameter int N_IN = 14,
    parameter int N_FB = 8
) (
    input  logic [N_IN-1:0]            in_ded,
    input  logic [N_FB-1:0]            in_fb,
    output logic [2*(N_IN+N_FB)-1:0]   lines
);
    localparam int N_SIG = N_IN + N_FB;

    logic [N_SIG-1:0] sig;
    assign sig = {in_fb, in_ded};

    for (genvar s = 0; s < N_SIG; s++) begin : g_sig
        assign lines[2*s]   = sig[s];
        assign lines[2*s+1] = ~sig[s];
    end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int LINES = 44,
    parameter int TERMS = 74
) (
    input  logic [TERMS-1:0][LINES-1:0] fuse_map,
    input  logic [LINES-1:0]            lines,
    output logic [TERMS-1:0]            terms
);
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        // An open connection contributes a constant 1 to the AND.
        assign terms[t] = &(lines | ~fuse_map[t]);
    end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_OUT = 8,
    parameter int TPO   = 8,
    parameter int TERMS = 74
) (
    input  logic [TERMS-1:0] terms,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_term,
    output logic             preset_term,
    output logic             clear_term
);
    localparam int SUM_TERMS = N_OUT * TPO;
    localparam int OE_BASE   = SUM_TERMS;
    localparam int PRE_IDX   = OE_BASE + N_OUT;
    localparam int CLR_IDX   = PRE_IDX + 1;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assign sum_out[k] = |terms[k*TPO +: TPO];
        assign oe_term[k] = terms[OE_BASE + k];
    end

    assign preset_term = terms[PRE_IDX];
    assign clear_term  = terms[CLR_IDX];
endmodule

// File: rtl/sop_fuse_store.sv
module sop_fuse_store
    import sop_pkg::*;
#(
    parameter int LINES = 44,
    parameter int TERMS = 74
) (
    input  logic                        clk,
    input  logic                        rst,
    input  cfg_req_t                    req,
    output logic [TERMS-1:0][LINES-1:0] fuse_map,
    output logic                        rd_bit,
    output logic                        lock_q,
    output logic                        wr_idle
);
    localparam int TW = $clog2(TERMS);
    localparam int LW = $clog2(LINES);
    localparam logic [TW-1:0] LAST_TERM = TW'(TERMS - 1);
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

    typedef struct packed {
        logic [TW-1:0] term;
        logic [LW-1:0] line;
    } fptr_t;

    fptr_t    wr_q;
    fptr_t    rd_q;
    ctl_act_e act;
    logic     write_ok;
    logic     read_ok;

    function automatic fptr_t step(fptr_t p);
        fptr_t n;
        n = p;
        if (p.line == LAST_LINE) begin
            n.line = '0;
            n.term = (p.term == LAST_TERM) ? '0 : p.term + 1'b1;
        end else begin
            n.line = p.line + 1'b1;
        end
        return n;
    endfunction

    assign wr_idle  = (wr_q == '0);
    assign act      = pick_action(req.erase, req.secure, lock_q, wr_idle, req.load);
    assign write_ok = (act != ACT_ERASE) && !lock_q && req.load;
    assign read_ok  = (act != ACT_ERASE) && req.read;

    always_ff @(posedge clk) begin
        if (rst || act == ACT_ERASE) begin
            fuse_map <= '0;
            wr_q     <= '0;
            rd_q     <= '0;
            lock_q   <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            if (act == ACT_SECURE)
                lock_q <= 1'b1;
            if (write_ok) begin
                fuse_map[wr_q.term][wr_q.line] <= req.din;
                wr_q <= step(wr_q);
            end
            if (read_ok) begin
                if (lock_q) begin
                    rd_bit <= 1'b0;
                end else begin
                    rd_bit <= fuse_map[rd_q.term][rd_q.line];
                    rd_q   <= step(rd_q);
                end
            end
        end
    end
endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int N_IN  = 14,
    parameter int N_FB  = 8,
    parameter int N_OUT = 8,
    parameter int TPO   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  in_ded,
    input  logic [N_FB-1:0]  in_fb,
    input  logic             cfg_load,
    input  logic             cfg_din,
    input  logic             cfg_read,
    output logic             cfg_dout,
    input  logic             cmd_erase,
    input  logic             cmd_secure,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_term,
    output logic             preset_term,
    output logic             clear_term
);
    localparam int LINES = line_count(N_IN, N_FB);
    localparam int TERMS = term_count(N_OUT, TPO);

    cfg_req_t                    req;
    logic [TERMS-1:0][LINES-1:0] fuse_map;
    logic [LINES-1:0]            lines;
    logic [TERMS-1:0]            terms;
    logic                        lock_q;
    logic                        wr_idle;

    assign req = '{load: cfg_load, din: cfg_din, read: cfg_read,
                   erase: cmd_erase, secure: cmd_secure};

    sop_fuse_store #(.LINES(LINES), .TERMS(TERMS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .fuse_map (fuse_map),
        .rd_bit   (cfg_dout),
        .lock_q   (lock_q),
        .wr_idle  (wr_idle)
    );

    sop_line_expand #(.N_IN(N_IN), .N_FB(N_FB)) u_lines (
        .in_ded (in_ded),
        .in_fb  (in_fb),
        .lines  (lines)
    );

    sop_and_plane #(.LINES(LINES), .TERMS(TERMS)) u_and (
        .fuse_map (fuse_map),
        .lines    (lines),
        .terms    (terms)
    );

    sop_or_plane #(.N_OUT(N_OUT), .TPO(TPO), .TERMS(TERMS)) u_or (
        .terms       (terms),
        .sum_out     (sum_out),
        .oe_term     (oe_term),
        .preset_term (preset_term),
        .clear_term  (clear_term)
    );
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int LINES = 44,
    parameter int TERMS = 74,
    parameter int N_OUT = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cfg_load,
    input logic                        cfg_read,
    input logic                        cfg_dout,
    input logic                        cmd_erase,
    input logic                        cmd_secure,
    input logic [N_OUT-1:0]            sum_out,
    input logic [N_OUT-1:0]            oe_term,
    input logic                        preset_term,
    input logic                        clear_term,
    input logic                        lock_q,
    input logic                        wr_idle,
    input logic [TERMS-1:0][LINES-1:0] fuse_map
);
    // R7: after an erase every term is open, so every output is 1
    p_erase_opens_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_erase |=> ((&sum_out) && (&oe_term) && preset_term && clear_term));

    // R7: erase rewinds the write pointer and clears the readback bit
    p_erase_rewinds_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_erase |=> (wr_idle && !cfg_dout && !lock_q));

    // R9: a locked store answers reads with 0
    p_locked_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (lock_q && cfg_read && !cmd_erase) |=> !cfg_dout);

    // R9: a locked store keeps its map
    p_locked_map_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !cmd_erase) |=> $stable(fuse_map));

    // R8: a lock request during a load is dropped
    p_secure_midload_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!lock_q && !cmd_erase && cmd_secure && (!wr_idle || cfg_load)) |=> !lock_q);

    // R8: a lock request on an idle store takes effect
    p_secure_idle_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (!cmd_erase && cmd_secure && wr_idle && !cfg_load) |=> lock_q);

    // R10: only erase (or reset) removes the lock
    p_unlock_only_erase_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> ($past(cmd_erase) || $past(rst)));
endmodule

bind sop_array sop_array_chk #(.LINES(LINES), .TERMS(TERMS), .N_OUT(N_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_load    (cfg_load),
    .cfg_read    (cfg_read),
    .cfg_dout    (cfg_dout),
    .cmd_erase   (cmd_erase),
    .cmd_secure  (cmd_secure),
    .sum_out     (sum_out),
    .oe_term     (oe_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .lock_q      (lock_q),
    .wr_idle     (wr_idle),
    .fuse_map    (fuse_map)
);

// File: tb/sop_array_test.sv
module sop_array_test;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 3;
    localparam int NF = 2;
    localparam int NO = 2;
    localparam int TP = 2;
    localparam int LN = 2 * (NI + NF);
    localparam int TM = NO * TP + NO + 2;
    localparam int NB = TM * LN;
    localparam int NV = 1 << (NI + NF);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] in_ded = '0;
    logic [NF-1:0] in_fb = '0;
    logic          cfg_load = 1'b0;
    logic          cfg_din = 1'b0;
    logic          cfg_read = 1'b0;
    logic          cfg_dout;
    logic          cmd_erase = 1'b0;
    logic          cmd_secure = 1'b0;
    logic [NO-1:0] sum_out;
    logic [NO-1:0] oe_term;
    logic          preset_term;
    logic          clear_term;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  fmap [NB];
    bit  model_locked = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_array #(.N_IN(NI), .N_FB(NF), .N_OUT(NO), .TPO(TP)) uut (
        .clk(clk), .rst(rst), .in_ded(in_ded), .in_fb(in_fb),
        .cfg_load(cfg_load), .cfg_din(cfg_din), .cfg_read(cfg_read), .cfg_dout(cfg_dout),
        .cmd_erase(cmd_erase), .cmd_secure(cmd_secure),
        .sum_out(sum_out), .oe_term(oe_term), .preset_term(preset_term), .clear_term(clear_term)
    );

    function automatic bit pat(int which, int i);
        int t = i / LN;
        int l = i % LN;
        case (which)
            0: return ((t * 7 + l * 3) % 5) == 0;
            1: return (t % 2 == 0) ? ((l / 2) == (t % (NI + NF))) : (l == (t % LN));
            default: return ((t * 7 + l * 3) % 5) != 0;
        endcase
    endfunction

    // R1: line 2s is signal s, line 2s+1 its complement; signals are {fb, ded}
    function automatic bit line_val(int l, int v);
        bit b = v[l / 2];
        return (l % 2) ? !b : b;
    endfunction

    // R2: AND of selected lines, 1 when none selected
    function automatic bit term_val(int t, int v);
        bit r = 1'b1;
        for (int l = 0; l < LN; l++)
            if (fmap[t * LN + l] && !line_val(l, v)) r = 1'b0;
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R3: sweep every input combination against the model outputs
    task automatic sweep(string tag);
        for (int v = 0; v < NV; v++) begin
            logic [NO-1:0] es;
            logic [NO-1:0] eo;
            @(negedge clk);
            in_ded = v[NI-1:0];
            in_fb  = v[NI+NF-1:NI];
            #1;
            for (int k = 0; k < NO; k++) begin
                es[k] = 1'b0;
                for (int p = 0; p < TP; p++) es[k] = es[k] | term_val(k * TP + p, v);
                eo[k] = term_val(NO * TP + k, v);
            end
            check(tag, {clear_term, preset_term, oe_term, sum_out},
                  {term_val(NO * TP + NO + 1, v), term_val(NO * TP + NO, v), eo, es});
        end
    endtask

    task automatic load_range(int which, int lo, int hi);
        for (int i = lo; i < hi; i++) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_din  = pat(which, i);
            if (!model_locked) fmap[i] = pat(which, i);
        end
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic read_check(string tag, bit expect_zero);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            cfg_read = 1'b1;
            @(negedge clk);
            cfg_read = 1'b0;
            check(tag, cfg_dout, expect_zero ? 0 : fmap[i]);
        end
    endtask

    task automatic pulse_erase();
        @(negedge clk);
        cmd_erase = 1'b1;
        @(negedge clk);
        cmd_erase = 1'b0;
        for (int i = 0; i < NB; i++) fmap[i] = 1'b0;
        model_locked = 1'b0;
    endtask

    task automatic pulse_secure(bit take);
        @(negedge clk);
        cmd_secure = 1'b1;
        @(negedge clk);
        cmd_secure = 1'b0;
        if (take) model_locked = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) fmap[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: erased array, every output 1, readback idle
        check("R6 outputs", {clear_term, preset_term, oe_term, sum_out}, (1 << (2 * NO + 2)) - 1);
        check("R6 dout", cfg_dout, 0);

        load_range(0, 0, NB);
        sweep("R1 R2 R3 R4 pattern A");
        read_check("R5 readback A", 1'b0);

        load_range(1, 0, NB);
        sweep("R2 contradiction pattern B");

        // R4 and R8: split load with a lock request in the gap
        load_range(0, 0, 10);
        pulse_secure(1'b0);
        load_range(0, 10, NB);
        read_check("R8 midload lock ignored", 1'b0);
        sweep("R4 split load");

        // R9: lock, then attempt to reprogram
        pulse_secure(1'b1);
        read_check("R9 locked readback", 1'b1);
        load_range(2, 0, NB);
        sweep("R9 locked map kept");
        read_check("R10 lock persists", 1'b1);

        // R7: erase clears map and lock
        pulse_erase();
        sweep("R7 erased");
        load_range(1, 0, NB);
        read_check("R7 R10 unlocked after erase", 1'b0);

        // R7: erase mid-load rewinds the write pointer
        load_range(0, 0, 15);
        pulse_erase();
        load_range(0, 0, NB);
        read_check("R7 pointer rewound", 1'b0);

        // R7: erase wins over a same-cycle load
        @(negedge clk);
        cmd_erase = 1'b1;
        cfg_load  = 1'b1;
        cfg_din   = 1'b1;
        @(negedge clk);
        cmd_erase = 1'b0;
        cfg_load  = 1'b0;
        for (int i = 0; i < NB; i++) fmap[i] = 1'b0;
        sweep("R7 erase over load");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule